// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter Stage

This block is one stage of a synchronous binary counter that steps up or down on each rising clock edge. A high level on the direction input selects counting up and a low level selects counting down. Two inputs act without the clock. A clear input forces the count to zero, and a load input forces the count to a parallel preset word. Clear outranks load, and both of them hold the counter still while they are high.

Counting is gated by an active-low chain input. The stage also drives an active-low chain output that goes low when the stage sits at its terminal value for the current direction and its own chain input is low. The terminal value is all ones when counting up and all zeros when counting down. Identical stages share one clock and are chained by wiring each chain output to the next stage's chain input. This builds wider counters in which every upper stage advances once for each full wrap of the stage below it.

Top module: `updown_stage`

## Requirements
- R1: The count changes on a rising clock edge only. A change of direction or chain input between edges leaves `count_o` unchanged until the next edge.
- R2: While `rst_i` is high, `count_o` reads zero at once, without waiting for a clock edge. This holds whatever the other inputs do, load included.
- R3: While `load_i` is high and `rst_i` is low, `count_o` follows `preset_i` at once. After `load_i` falls, the count keeps that value until the next enabled edge. `preset_i` must be stable over the last clock edge before `load_i` falls.
- R4: While `cin_n_i` is high, clock edges leave the count unchanged.
- R5: With `up_i` = 1 and `cin_n_i` = 0, each edge adds one to the count, and 15 wraps to 0. Bit 0 of `count_o` is the least significant bit.
- R6: With `up_i` = 0 and `cin_n_i` = 0, each edge subtracts one from the count, and 0 wraps to 15.
- R7: With `up_i` = 1, `cout_n_o` is 0 exactly when `count_o` is 15 and `cin_n_i` is 0. Otherwise it is 1.
- R8: With `up_i` = 0, `cout_n_o` is 0 exactly when `count_o` is 0 and `cin_n_i` is 0. Otherwise it is 1.
- R9: Two stages on a shared clock, with the lower stage's `cout_n_o` driving the upper stage's `cin_n_i`, behave as one 8-bit up/down counter. The 8-bit count is {upper, lower}, and it wraps 255 to 0 when counting up and 0 to 255 when counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock, rising edge active |
| rst_i | input | 1 | Asynchronous clear, active high, highest priority |
| load_i | input | 1 | Asynchronous preset load, active high |
| preset_i | input | WIDTH | Preset word |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| cin_n_i | input | 1 | Active-low count enable / chain input |
| count_o | output | WIDTH | Current count, bit 0 least significant |
| cout_n_o | output | 1 | Active-low terminal-count chain output |

## Verification
The assertions check the following at every clock edge: the one-step increment, decrement and hold across consecutive edges, the preset being visible while the load input is high, and the level of the chain output for each direction. Some behaviours show up only in the bench's scenarios. These are the values taken between edges when clear or load rises in mid-cycle, the count held after the load input falls, the absence of change when inputs move between edges, and the carry timing of a two-stage cascade across its wrap points. The cascade is compared against an 8-bit arithmetic model while the direction reverses at those wrap points.

// File: rtl/updown_pkg.sv
package updown_pkg;
  // Direction encoding on the up_i pin
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/ud_next.sv
module ud_next #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] nxt_o
);
  import updown_pkg::*;

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // Modular step; wrap falls out of the fixed-width arithmetic
  function automatic logic [WIDTH-1:0] step_value(
    input logic [WIDTH-1:0] v,
    input dir_e             d
  );
    logic [WIDTH-1:0] r;
    if (d == DIR_UP) r = v + ONE;
    else             r = v - ONE;
    return r;
  endfunction

  always_comb begin
    nxt_o = step_value(cur_i, dir_e'(up_i));
  end
endmodule

// File: rtl/ud_carry.sv
module ud_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_i,
  input  logic             cin_n_i,
  output logic             at_term_o,
  output logic             cout_n_o
);
  import updown_pkg::*;

  localparam logic [WIDTH-1:0] ALL_ONES  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ZEROS = {WIDTH{1'b0}};

  // Terminal value depends on direction: top of range up, bottom down
  function automatic logic is_terminal(
    input logic [WIDTH-1:0] v,
    input dir_e             d
  );
    logic t;
    if (d == DIR_UP) t = (v == ALL_ONES);
    else             t = (v == ALL_ZEROS);
    return t;
  endfunction

  always_comb begin
    at_term_o = is_terminal(cnt_i, dir_e'(up_i));
    cout_n_o  = ~(at_term_o & ~cin_n_i);
  end
endmodule

// File: rtl/ud_state.sv
module ud_state #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);
  // Clear and load both act without the clock; clear wins
  always_ff @(posedge clk_i or posedge rst_i or posedge load_i) begin
    if (rst_i)       q_o <= '0;
    else if (load_i) q_o <= preset_i;
    else if (adv_i)  q_o <= nxt_i;
  end
endmodule

// File: rtl/updown_stage.sv
module updown_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             up_i,
  input  logic             cin_n_i,
  output logic [WIDTH-1:0] count_o,
  output logic             cout_n_o
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

  // Named internal events
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] next_val;
  logic             count_en;
  logic             at_term;
  logic             armed_q;

  assign count_en = ~cin_n_i;

  ud_next #(.WIDTH(WIDTH)) next_i (
    .cur_i (state_q),
    .up_i  (up_i),
    .nxt_o (next_val)
  );

  ud_state #(.WIDTH(WIDTH)) state_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load_i),
    .preset_i (preset_i),
    .adv_i    (count_en),
    .nxt_i    (next_val),
    .q_o      (state_q)
  );

  // Visible count: clear and load are transparent while held
  always_comb begin
    if (rst_i)       count_o = '0;
    else if (load_i) count_o = preset_i;
    else             count_o = state_q;
  end

  ud_carry #(.WIDTH(WIDTH)) carry_i (
    .cnt_i     (count_o),
    .up_i      (up_i),
    .cin_n_i   (cin_n_i),
    .at_term_o (at_term),
    .cout_n_o  (cout_n_o)
  );

  // Marks that at least one edge has passed since clear
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) armed_q <= 1'b0;
    else       armed_q <= 1'b1;
  end

  // R2
  reset_zero_chk: assert property (@(posedge clk_i)
    rst_i |-> (count_o == '0));

  // R3
  preset_view_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |-> (count_o == preset_i));

  // R4
  hold_inhibit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_q && !load_i && $past(!load_i) && $past(!rst_i) && $past(cin_n_i))
      |-> (count_o == $past(count_o)));

  // R5
  step_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_q && !load_i && $past(!load_i) && $past(!rst_i) &&
     $past(!cin_n_i) && $past(up_i))
      |-> (count_o == $past(count_o) + ONE));

  // R6
  step_down_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_q && !load_i && $past(!load_i) && $past(!rst_i) &&
     $past(!cin_n_i) && $past(!up_i))
      |-> (count_o == $past(count_o) - ONE));

  // R7
  carry_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    up_i |-> (cout_n_o == !(count_o == MAX_VAL && !cin_n_i)));

  // R8
  carry_down_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !up_i |-> (cout_n_o == !(count_o == '0 && !cin_n_i)));

  // R7 R8: terminal flag never claims a terminal on a non-extreme value
  term_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    at_term |-> (count_o == '0 || count_o == MAX_VAL));
endmodule

// File: tb/updown_stage_tb_top.sv
`timescale 1ns/1ps
module updown_stage_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       s_load, s_up, s_cin_n;
  logic [3:0] s_preset;
  logic [3:0] s_count;
  logic       s_cout_n;

  logic       c_load, c_up, c_cin_n;
  logic [7:0] c_preset;
  logic [3:0] c_lo, c_hi;
  logic       c_mid_n, c_top_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  updown_stage #(.WIDTH(4)) dut_i (
    .clk_i(clk), .rst_i(rst), .load_i(s_load), .preset_i(s_preset),
    .up_i(s_up), .cin_n_i(s_cin_n), .count_o(s_count), .cout_n_o(s_cout_n)
  );

  updown_stage #(.WIDTH(4)) casc_lo_i (
    .clk_i(clk), .rst_i(rst), .load_i(c_load), .preset_i(c_preset[3:0]),
    .up_i(c_up), .cin_n_i(c_cin_n), .count_o(c_lo), .cout_n_o(c_mid_n)
  );

  updown_stage #(.WIDTH(4)) casc_hi_i (
    .clk_i(clk), .rst_i(rst), .load_i(c_load), .preset_i(c_preset[7:4]),
    .up_i(c_up), .cin_n_i(c_mid_n), .count_o(c_hi), .cout_n_o(c_top_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_cout(input int v, input int up, input int cin_n);
    int term;
    term = up ? (v == 15) : (v == 0);
    return (term && cin_n == 0) ? 0 : 1;
  endfunction

  initial begin
    rst = 1'b1; s_load = 0; s_up = 1; s_cin_n = 0; s_preset = 0;
    c_load = 0; c_up = 1; c_cin_n = 0; c_preset = 0;
    repeat (3) tick();
    // R2 reset state
    chk(s_count == 0, "R2 reset count", s_count, 0);
    chk(s_cout_n == 1, "R7 cout at reset (up, count 0)", s_cout_n, 1);
    rst = 1'b0;
    tick();
    chk(s_count == 1, "R5 first step after reset", s_count, 1);

    // R2 asynchronous clear mid-cycle, also overriding load
    s_cin_n = 1'b1;
    s_preset = 4'd9; s_load = 1'b1;
    #1 chk(s_count == 9, "R3 async load mid-cycle", s_count, 9);
    s_preset = 4'd12;
    #0.2 chk(s_count == 12, "R3 count follows preset while loading", s_count, 12);
    rst = 1'b1;
    #0.2 chk(s_count == 0, "R2 async clear overrides load", s_count, 0);
    tick();
    chk(s_count == 0, "R2 clear blocks clock", s_count, 0);
    rst = 1'b0;
    tick();
    s_load = 1'b0;
    #0.5 chk(s_count == 12, "R3 hold after load falls", s_count, 12);
    tick();
    chk(s_count == 12, "R4 inhibit with cin high", s_count, 12);

    // R1: inputs moving between edges change nothing
    s_cin_n = 1'b0; s_up = 1'b0;
    #1 chk(s_count == 12, "R1 no change before edge", s_count, 12);
    s_up = 1'b1;
    #0.5 chk(s_count == 12, "R1 direction toggle between edges", s_count, 12);
    tick();
    chk(s_count == 13, "R5 step at edge", s_count, 13);

    // Exhaustive sweep: every value, direction and enable
    for (int v = 0; v < 16; v++) begin
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < 2; c++) begin
          int nv;
          s_load = 1'b1; s_preset = 4'(v); s_up = d[0]; s_cin_n = c[0];
          #0.5 chk(s_count == v, "R3 preset value", s_count, v);
          tick();
          s_load = 1'b0;
          #0.5 chk(s_count == v, "R3 held after load", s_count, v);
          if (d == 1) chk(s_cout_n == exp_cout(v, d, c), "R7 cout up", s_cout_n, exp_cout(v, d, c));
          else        chk(s_cout_n == exp_cout(v, d, c), "R8 cout down", s_cout_n, exp_cout(v, d, c));
          tick();
          if (c == 1)      nv = v;
          else if (d == 1) nv = (v + 1) % 16;
          else             nv = (v + 15) % 16;
          if (c == 1)      chk(s_count == nv, "R4 hold", s_count, nv);
          else if (d == 1) chk(s_count == nv, "R5 up step", s_count, nv);
          else             chk(s_count == nv, "R6 down step", s_count, nv);
        end
      end
    end

    // R9 cascade against an 8-bit model
    begin
      int ref_v;
      logic [7:0] lfsr;
      ref_v = 250;
      c_preset = 8'd250; c_load = 1'b1; c_cin_n = 1'b0; c_up = 1'b1;
      tick();
      c_load = 1'b0;
      #0.5 chk({c_hi, c_lo} == 8'd250, "R9 cascade preset", {c_hi, c_lo}, 250);
      lfsr = 8'hA5;
      for (int i = 0; i < 1200; i++) begin
        if (i < 600) begin
          c_up = ((i / 23) % 2) == 0;
          c_cin_n = (i % 37) == 36;
        end else begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          c_up = lfsr[0] | lfsr[1];
          c_cin_n = (lfsr[7:5] == 3'b111);
        end
        #0.5;
        chk(c_top_n == (({c_hi, c_lo} == (c_up ? 8'hFF : 8'h00) && !c_cin_n) ? 1'b0 : 1'b1),
            "R9 cascade top carry", c_top_n,
            ({c_hi, c_lo} == (c_up ? 8'hFF : 8'h00) && !c_cin_n) ? 0 : 1);
        tick();
        if (!c_cin_n) ref_v = c_up ? (ref_v + 1) % 256 : (ref_v + 255) % 256;
        chk({c_hi, c_lo} == ref_v, "R9 cascade count", {c_hi, c_lo}, ref_v);
      end
    end

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule